// File: doc/BRIEF.md
# Triggered Sample Timestamp Capture Unit

This block stamps every sample event of a separate sampling timer with a count taken from a fast reference clock. The block runs on that reference clock. A prescaler divides it into count ticks, and a 16-bit counter advances once per tick. The counter wraps to zero after a programmed maximum, which is set to the period minus one. The period is chosen so that the counter wraps once per sample batch.

Trigger lines arrive from the sampling-timer domain. One line is picked by a select field. It passes through a two-flop synchronizer and a rising-edge detector, so each pulse gives exactly one capture. When the capture source is set to the internal trigger, each capture writes the counter into the filling half of a ping-pong store whose halves each hold one batch. When a half fills, writing moves to the other half without losing a capture. A completion flag then rises. A read strobe aimed at the completed half clears that flag. If a half completes while the flag is still set, a sticky overrun flag is raised.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, `done`, `overrun` and `active_buf` are 0, and every entry of both buffers reads 0.
- R2: `cfg_div` sets the tick rate. 2'b00 makes one tick every clock, 2'b01 every 2 clocks, 2'b10 every 4 clocks and 2'b11 every 8 clocks. The counter advances by one per tick.
- R3: On a tick where the counter is at or above `cfg_top`, the counter becomes 0 instead of incrementing.
- R4: A rising edge on the selected trigger line gives exactly one capture, however long the line stays high. The stored value is the counter value that holds after the third rising clock edge following the trigger edge: two synchronizer stages, then the edge-detected write.
- R5: Only the line `trig_lines[cfg_line]` triggers captures. Edges on the other lines store nothing and do not advance the write position.
- R6: Captures happen only when `cfg_src` is 2'b11 (internal trigger). With 2'b00, 2'b01 or 2'b10, trigger edges store nothing and do not advance the write position.
- R7: Captures fill indices 0 to BATCH-1 of the half named by `active_buf`, in arrival order. After the last index is written, `active_buf` toggles and the next capture goes to index 0 of the other half.
- R8: `done` rises in the clock in which a half completes. A `rd_en` pulse with `rd_buf` not equal to `active_buf` clears it. `rd_data` always shows entry `rd_idx` of half `rd_buf`.
- R9: If a half completes while `done` is set and no clearing read happens in that clock, `overrun` rises and stays 1 until reset.
- R10: A capture whose write clock is also a counter wrap clock stores 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; everything runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_lines | input | NLINE | Trigger lines from the sampling-timer domain, asynchronous |
| cfg_div | input | 2 | Prescaler code |
| cfg_top | input | CNT_W | Counter maximum (period minus one) |
| cfg_src | input | 2 | Capture source; 2'b11 is the internal trigger |
| cfg_line | input | $clog2(NLINE) | Which trigger line is used |
| rd_en | input | 1 | Read strobe; clears `done` when aimed at the completed half |
| rd_buf | input | 1 | Half of the store to read |
| rd_idx | input | $clog2(BATCH) | Entry to read |
| rd_data | output | CNT_W | Stored timestamp at `rd_buf`/`rd_idx` |
| done | output | 1 | A half has completed and has not been read |
| overrun | output | 1 | Sticky: a half completed before the previous one was read |
| active_buf | output | 1 | Half currently being filled |

## Verification
The bench uses the default build: a 16-bit counter, batches of 8 and four trigger lines. It programs small maxima such as 40 and 300 so that wraps fall inside a batch. It also uses the full 16-bit maximum at the slowest divide. A reference count kept in the bench, run from the same divide and maximum, gives the expected timestamp for each capture. That makes it possible to aim one capture exactly at a wrap clock. Eight captures per batch let both halves fill and swap several times. Sixteen captures with no read reach the overrun case.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_IN13 = 2'b01,
        SRC_IN24 = 2'b10,
        SRC_TRIG = 2'b11
    } cap_src_e;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } div_code_e;
endpackage

// File: rtl/ts_timebase.sv
module ts_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       div_sel,
    input  logic [CNT_W-1:0] top_val,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_now,
    output logic [CNT_W-1:0] cnt_next
);
    import ts_pkg::*;

    typedef struct packed {
        logic [2:0]       pre;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic [2:0] term;

    always_comb begin
        case (div_code_e'(div_sel))
            DIV_1:   term = 3'd0;
            DIV_2:   term = 3'd1;
            DIV_4:   term = 3'd3;
            default: term = 3'd7;
        endcase
        s_d  = s_q;
        tick = (s_q.pre >= term);
        if (tick) begin
            s_d.pre = 3'd0;
            if (s_q.cnt >= top_val) s_d.cnt = '0;
            else                    s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_now  = s_q.cnt;
    assign cnt_next = s_d.cnt;
endmodule

// File: rtl/ts_trig_sync.sv
module ts_trig_sync #(
    parameter int NLINE  = 4,
    localparam int SEL_W = $clog2(NLINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] lines,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    typedef struct packed {
        logic [NLINE-1:0] m1;
        logic [NLINE-1:0] m2;
        logic [NLINE-1:0] m3;
    } sy_state_t;

    sy_state_t s_d, s_q;

    always_comb begin
        s_d.m1 = lines;
        s_d.m2 = s_q.m1;
        s_d.m3 = s_q.m2;
        pulse  = s_q.m2[sel] & ~s_q.m3[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ts_pingpong.sv
module ts_pingpong #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          ack_en,
    input  logic          rd_buf,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          done,
    output logic          overrun,
    output logic          active
);
    typedef struct packed {
        logic [1:0][DEPTH-1:0][W-1:0] mem;
        logic [IW-1:0]                idx;
        logic                         act;
        logic                         done;
        logic                         ovr;
    } pp_state_t;

    pp_state_t s_d, s_q;
    logic ack;

    always_comb begin
        s_d = s_q;
        ack = ack_en && (rd_buf != s_q.act);
        if (ack) s_d.done = 1'b0;
        if (wr_en) begin
            s_d.mem[s_q.act][s_q.idx] = wr_data;
            if (s_q.idx == IW'(DEPTH - 1)) begin
                s_d.idx  = '0;
                s_d.act  = ~s_q.act;
                s_d.done = 1'b1;
                if (s_q.done && !ack) s_d.ovr = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.mem[rd_buf][rd_idx];
    assign done    = s_q.done;
    assign overrun = s_q.ovr;
    assign active  = s_q.act;
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
    parameter int CNT_W   = 16,
    parameter int BATCH   = 8,
    parameter int NLINE   = 4,
    localparam int IDX_W  = $clog2(BATCH),
    localparam int LSEL_W = $clog2(NLINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINE-1:0]  trig_lines,
    input  logic [1:0]        cfg_div,
    input  logic [CNT_W-1:0]  cfg_top,
    input  logic [1:0]        cfg_src,
    input  logic [LSEL_W-1:0] cfg_line,
    input  logic              rd_en,
    input  logic              rd_buf,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_data,
    output logic              done,
    output logic              overrun,
    output logic              active_buf
);
    import ts_pkg::*;

    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cnt_nx;
    logic             trig_pulse;
    logic             cap_we;

    ts_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (cfg_div),
        .top_val  (cfg_top),
        .tick     (tick_w),
        .cnt_now  (cnt_w),
        .cnt_next (cnt_nx)
    );

    ts_trig_sync #(.NLINE(NLINE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (trig_lines),
        .sel   (cfg_line),
        .pulse (trig_pulse)
    );

    assign cap_we = trig_pulse && (cap_src_e'(cfg_src) == SRC_TRIG);

    ts_pingpong #(.W(CNT_W), .DEPTH(BATCH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_we),
        .wr_data (cnt_nx),
        .ack_en  (rd_en),
        .rd_buf  (rd_buf),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .done    (done),
        .overrun (overrun),
        .active  (active_buf)
    );
endmodule

// File: rtl/ts_capture_chk.sv
module ts_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             overrun,
    input logic             active_buf,
    input logic             rd_en,
    input logic             rd_buf,
    input logic             trig_pulse,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top
);
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_done_on_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_buf != $past(active_buf)) |-> done);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_buf != active_buf)) |=> (!done || (active_buf != $past(active_buf))));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt >= top)) |=> (cnt == '0));
endmodule

bind ts_capture_unit ts_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .overrun    (overrun),
    .active_buf (active_buf),
    .rd_en      (rd_en),
    .rd_buf     (rd_buf),
    .trig_pulse (trig_pulse),
    .tick       (tick_w),
    .cnt        (cnt_w),
    .top        (cfg_top)
);

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb;
    localparam int CLK_P = 10;
    localparam int CNT_W = 16;
    localparam int BATCH = 8;
    localparam int NLINE = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NLINE-1:0] trig_lines = '0;
    logic [1:0]       cfg_div = 2'b00;
    logic [CNT_W-1:0] cfg_top = 16'd40;
    logic [1:0]       cfg_src = 2'b11;
    logic [1:0]       cfg_line = 2'd1;
    logic             rd_en = 1'b0;
    logic             rd_buf = 1'b0;
    logic [2:0]       rd_idx = '0;
    logic [CNT_W-1:0] rd_data;
    logic             done, overrun, active_buf;

    int total = 0;
    int bad = 0;

    logic [CNT_W-1:0] exp_mem [2][BATCH];
    int ebuf = 0;
    int eidx = 0;

    logic [2:0]       m_p;
    logic [CNT_W-1:0] m_c;

    // prescaler code, counter maximum
    localparam logic [17:0] VEC [4] = '{
        {2'b00, 16'd40},
        {2'b01, 16'd300},
        {2'b10, 16'd1000},
        {2'b11, 16'd65535}
    };

    ts_capture_unit #(.CNT_W(CNT_W), .BATCH(BATCH), .NLINE(NLINE)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_lines(trig_lines), .cfg_div(cfg_div),
        .cfg_top(cfg_top), .cfg_src(cfg_src), .cfg_line(cfg_line), .rd_en(rd_en),
        .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_data(rd_data), .done(done),
        .overrun(overrun), .active_buf(active_buf)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference count from R2/R3
    always @(posedge clk) begin
        if (!rst_n) begin
            m_p <= '0;
            m_c <= '0;
        end else if (m_p >= 3'((1 << cfg_div) - 1)) begin
            m_p <= '0;
            m_c <= (m_c >= cfg_top) ? '0 : m_c + 1'b1;
        end else begin
            m_p <= m_p + 3'd1;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_line(input int ln);
        @(negedge clk);
        trig_lines[ln] = 1'b1;
        repeat (4) @(negedge clk);
        trig_lines[ln] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // One capture on the selected line; expected value per R4
    task automatic capture(input int hold, input bit align, output logic [CNT_W-1:0] v);
        @(negedge clk);
        if (align) while (m_c != cfg_top - 2) @(negedge clk);
        trig_lines[cfg_line] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        v = m_c;
        exp_mem[ebuf][eidx] = v;
        if (eidx == BATCH - 1) begin
            eidx = 0;
            ebuf = 1 - ebuf;
        end else begin
            eidx++;
        end
        repeat (hold) @(negedge clk);
        trig_lines[cfg_line] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_check(input int b, input string tag);
        for (int i = 0; i < BATCH; i++) begin
            @(negedge clk);
            rd_buf = b[0];
            rd_idx = 3'(i);
            #1;
            chk(rd_data == exp_mem[b][i], tag, rd_data, exp_mem[b][i]);
        end
    endtask

    task automatic ack(input int b);
        @(negedge clk);
        rd_buf = b[0];
        rd_en  = 1'b1;
        @(negedge clk);
        rd_en  = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] v;
        int done_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", done, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);
        chk(active_buf == 1'b0, "R1 active_buf", active_buf, 0);
        rd_buf = 1'b1; rd_idx = 3'd5; #1;
        chk(rd_data == 0, "R1 buffer clear", rd_data, 0);

        // Table walk: R2, R3, R4, R7, R8 per prescaler setting
        for (int t = 0; t < 4; t++) begin
            cfg_div = VEC[t][17:16];
            cfg_top = VEC[t][15:0];
            done_b = ebuf;
            for (int k = 0; k < BATCH; k++) begin
                repeat ((k * 5 + t * 3) % 13) @(negedge clk);
                capture(0, 1'b0, v);
                if (k < BATCH - 1) chk(done == 1'b0, "R8 no early done", done, 0);
            end
            chk(done == 1'b1, "R8 done on fill", done, 1);
            chk(active_buf == ebuf[0], "R7 active swap", active_buf, ebuf);
            read_check(done_b, "R2 R3 R7 stored stamp");
            ack(done_b);
            chk(done == 1'b0, "R8 read clears done", done, 0);
        end

        // Directed: R5, R6, R4 hold, R10 in one batch
        cfg_div = 2'b00;
        cfg_top = 16'd40;
        done_b = ebuf;
        pulse_line(2);                // R5 other line ignored
        cfg_src = 2'b10; pulse_line(1);   // R6 ignored
        cfg_src = 2'b00; pulse_line(1);   // R6 ignored
        cfg_src = 2'b01; pulse_line(1);   // R6 ignored
        cfg_src = 2'b11;
        capture(12, 1'b0, v);         // R4 long high, one capture
        capture(0, 1'b1, v);          // R10 aligned with wrap
        chk(v == 0, "R10 aligned expectation", v, 0);
        for (int k = 0; k < BATCH - 3; k++) capture(0, 1'b0, v);
        chk(done == 1'b0, "R5 R6 ignored edges did not fill", done, 0);
        capture(0, 1'b0, v);
        chk(done == 1'b1, "R4 R5 R6 eighth capture completes", done, 1);
        read_check(done_b, "R4 R5 R6 stored order");
        @(negedge clk); rd_buf = done_b[0]; rd_idx = 3'd1; #1;
        chk(rd_data == 0, "R10 wrap capture stores zero", rd_data, 0);
        ack(done_b);

        // R9 overrun: two fills, no read
        for (int k = 0; k < 2 * BATCH; k++) capture(0, 1'b0, v);
        chk(done == 1'b1, "R9 done", done, 1);
        chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
        ack(1 - ebuf);
        repeat (3) @(negedge clk);
        chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

        // R1 again after reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(overrun == 1'b0, "R1 overrun cleared", overrun, 0);
        chk(active_buf == 1'b0, "R1 active after reset", active_buf, 0);
        rd_buf = 1'b0; rd_idx = 3'd2; #1;
        chk(rd_data == 0, "R1 buffer cleared", rd_data, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule